// File: doc/BRIEF.md
# Data-ready strobe generator with restart alignment

This block sits at the output of a high-speed sampling converter. It produces a data-ready strobe that travels with the converted words, so that capture or demultiplexing logic downstream can store the words in a known order. Samples enter on the rising edge of the free-running sample clock. The strobe toggles on falling edges, which gives a square wave at half the clock rate. The output word changes only on rising edges, so it is steady across both strobe edges.

An active-low command stops the strobe and restarts it. When the command falls, it clears the strobe and the alignment pipeline at once, without waiting for a clock edge, so a pulse of about one nanosecond is enough. The first rising edge of the sample clock after the command goes high registers the release. The strobe then starts on the falling edge that follows. As a result, the restart phase depends only on the clock level at the moment of release.

Each word after a restart carries a sample tag that counts from zero. The first sample taken after a restart is always on the output, with tag zero, when the third rising edge of the strobe occurs. Capture logic can therefore find word zero by counting strobe edges.

Top module: `drdy_strobe_gen`

## Requirements
- R1: A falling edge on `rdy_rst_n` drives `rdy_strobe` and `tag_vld` to 0 within the same half clock period, with no clock edge in between. A low pulse of 1 ns is enough.
- R2: While `rdy_rst_n` is low, `rdy_strobe`, `tag_vld`, `word_out` and `tag_out` stay at 0, whatever the sample clock does.
- R3: After release, once the strobe is running, `rdy_strobe` inverts on every falling edge of `smp_clk` for as long as `rdy_rst_n` stays high.
- R4: If `rdy_rst_n` rises while `smp_clk` is low, the first rising edge of the strobe is on the falling edge that follows the next rising clock edge. That is half a period after the rising edge that registers the release.
- R5: If `rdy_rst_n` rises while `smp_clk` is high, the falling edge that ends that high phase leaves the strobe at 0. The first strobe rising edge comes one full clock period after that falling edge.
- R6: The sample presented on `word_in` at the first rising clock edge after release is on `word_out`, with `tag_out` = 0 and `tag_vld` = 1, when the third strobe rising edge occurs. `tag_vld` is 0 before that point.
- R7: `word_out` and `tag_out` change only on rising edges of `smp_clk`, so they are stable across every strobe transition.
- R8: While running, `word_out` equals `word_in` delayed by 2*FIRST_EDGE-1 rising clock edges. `tag_out` rises by one on each rising edge and wraps modulo 2^TAG_W.
- R9: If `rdy_rst_n` is asserted again while the strobe is running, the strobe returns to 0 at once. On the next release, R4 to R6 apply again, measured from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Free-running sample clock; samples are taken on its rising edge |
| rdy_rst_n | input | 1 | Active-low, level-sensitive command that stops and restarts the strobe |
| word_in | input | WORD_W | Sample word from the converter pipeline |
| word_out | output | WORD_W | Aligned output word; changes on rising clock edges only |
| tag_out | output | TAG_W | Index of the output word counted from the last release |
| tag_vld | output | 1 | High once the first post-release sample has reached `word_out` |
| rdy_strobe | output | 1 | Data-ready strobe at half the clock rate |

## Verification
The hardest cases to reach are the two restart phases and short stop pulses. These require the release and the command fall to be placed at chosen points inside the high and low halves of the clock period, not on clock edges. The bench drops and releases the command at fixed sub-period offsets after a rising or falling clock edge. It includes a 1 ns pulse in each phase and a long hold across many clock edges. For each release it measures the time from release to the first strobe rise, then waits for the third strobe rise and checks the word and tag there.

// File: rtl/drdy_pkg.sv
package drdy_pkg;

  // Run state of the strobe: held low by the command, or running.
  typedef enum logic {
    ST_HELD = 1'b0,
    ST_RUN  = 1'b1
  } run_e;

  // Rising-edge stages needed so that the first post-release sample
  // reaches the output just before strobe rise number first_edge.
  function automatic int unsigned pipe_depth(input int unsigned first_edge);
    return 2 * first_edge - 1;
  endfunction

endpackage

// File: rtl/drdy_release.sv
module drdy_release (
  input  logic            clk_i,
  input  logic            cmd_n_i,
  output drdy_pkg::run_e  state_o
);
  import drdy_pkg::*;

  run_e st_q;
  run_e st_d;

  // A rising clock edge with the command high starts the run.
  always_comb begin
    st_d = st_q;
    if (st_q == ST_HELD) begin
      st_d = ST_RUN;
    end
  end

  always_ff @(posedge clk_i or negedge cmd_n_i) begin
    if (!cmd_n_i) begin
      st_q <= ST_HELD;
    end else begin
      st_q <= st_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/drdy_toggle.sv
module drdy_toggle (
  input  logic clk_i,
  input  logic cmd_n_i,
  input  logic run_i,
  output logic strobe_o
);
  logic str_q;
  logic str_d;
  logic str_en;

  assign str_en = run_i;

  always_comb begin
    str_d = str_q;
    if (str_en) begin
      str_d = ~str_q;
    end
  end

  // Falling-edge register; the command clears it without a clock.
  always_ff @(negedge clk_i or negedge cmd_n_i) begin
    if (!cmd_n_i) begin
      str_q <= 1'b0;
    end else begin
      str_q <= str_d;
    end
  end

  assign strobe_o = str_q;

endmodule

// File: rtl/drdy_tagger.sv
module drdy_tagger #(
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             cmd_n_i,
  output logic [TAG_W-1:0] tag_o
);
  logic [TAG_W-1:0] cnt_q;
  logic [TAG_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge cmd_n_i) begin
    if (!cmd_n_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tag_o = cnt_q;

endmodule

// File: rtl/drdy_align_pipe.sv
module drdy_align_pipe #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned DEPTH  = 5
) (
  input  logic              clk_i,
  input  logic              cmd_n_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [WORD_W-1:0] word_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              vld_o
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [WORD_W-1:0] w_q;
    logic [WORD_W-1:0] w_d;
    logic [TAG_W-1:0]  t_q;
    logic [TAG_W-1:0]  t_d;
    logic              v_q;
    logic              v_d;

    if (s == 0) begin : g_head
      // Any rising edge with the command high takes a real sample.
      always_comb begin
        w_d = word_i;
        t_d = tag_i;
        v_d = 1'b1;
      end
    end else begin : g_body
      always_comb begin
        w_d = g_stage[s-1].w_q;
        t_d = g_stage[s-1].t_q;
        v_d = g_stage[s-1].v_q;
      end
    end

    always_ff @(posedge clk_i or negedge cmd_n_i) begin
      if (!cmd_n_i) begin
        w_q <= '0;
        t_q <= '0;
        v_q <= 1'b0;
      end else begin
        w_q <= w_d;
        t_q <= t_d;
        v_q <= v_d;
      end
    end
  end

  assign word_o = g_stage[DEPTH-1].w_q;
  assign tag_o  = g_stage[DEPTH-1].t_q;
  assign vld_o  = g_stage[DEPTH-1].v_q;

endmodule

// File: rtl/drdy_strobe_gen.sv
module drdy_strobe_gen #(
  parameter int unsigned WORD_W     = 10,
  parameter int unsigned TAG_W      = 8,
  parameter int unsigned FIRST_EDGE = 3
) (
  input  logic              smp_clk,
  input  logic              rdy_rst_n,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out,
  output logic [TAG_W-1:0]  tag_out,
  output logic              tag_vld,
  output logic              rdy_strobe
);
  localparam int unsigned DEPTH = drdy_pkg::pipe_depth(FIRST_EDGE);

  drdy_pkg::run_e   run_st;
  logic             armed;
  logic [TAG_W-1:0] tag_cnt;

  drdy_release u_release (
    .clk_i   (smp_clk),
    .cmd_n_i (rdy_rst_n),
    .state_o (run_st)
  );

  assign armed = (run_st == drdy_pkg::ST_RUN);

  drdy_toggle u_toggle (
    .clk_i    (smp_clk),
    .cmd_n_i  (rdy_rst_n),
    .run_i    (armed),
    .strobe_o (rdy_strobe)
  );

  drdy_tagger #(.TAG_W(TAG_W)) u_tagger (
    .clk_i   (smp_clk),
    .cmd_n_i (rdy_rst_n),
    .tag_o   (tag_cnt)
  );

  drdy_align_pipe #(
    .WORD_W (WORD_W),
    .TAG_W  (TAG_W),
    .DEPTH  (DEPTH)
  ) u_pipe (
    .clk_i   (smp_clk),
    .cmd_n_i (rdy_rst_n),
    .word_i  (word_in),
    .tag_i   (tag_cnt),
    .word_o  (word_out),
    .tag_o   (tag_out),
    .vld_o   (tag_vld)
  );

endmodule

// File: rtl/drdy_strobe_chk.sv
module drdy_strobe_chk #(
  parameter int unsigned TAG_W      = 8,
  parameter int unsigned FIRST_EDGE = 3
) (
  input logic             clk,
  input logic             cmd_n,
  input logic             armed,
  input logic             strobe,
  input logic             tag_vld,
  input logic [TAG_W-1:0] tag_out
);
  localparam int unsigned NF_W = $clog2(2 * FIRST_EDGE) + 1;
  localparam logic [NF_W-1:0] NF_MAX = '1;
  localparam logic [NF_W-1:0] NF_HIT = NF_W'(2 * FIRST_EDGE - 2);

  // Running falling edges since release, saturating.
  logic [NF_W-1:0] nf_q;
  logic [NF_W-1:0] nf_d;

  always_comb begin
    nf_d = nf_q;
    if (armed && (nf_q != NF_MAX)) begin
      nf_d = nf_q + 1'b1;
    end
  end

  always_ff @(negedge clk or negedge cmd_n) begin
    if (!cmd_n) begin
      nf_q <= '0;
    end else begin
      nf_q <= nf_d;
    end
  end

  p_held_pos_r2: assert property (@(posedge clk)
    !cmd_n |-> (!strobe && !tag_vld && !armed));

  p_held_neg_r2: assert property (@(negedge clk)
    !cmd_n |-> (!strobe && !tag_vld));

  p_toggle_r3: assert property (@(negedge clk) disable iff (!cmd_n)
    (nf_q != '0) |-> (strobe != $past(strobe)));

  p_first_word_r6: assert property (@(negedge clk) disable iff (!cmd_n)
    (tag_vld && (tag_out == '0) && (nf_q != NF_MAX)) |-> ((nf_q == NF_HIT) && !strobe));

  p_tag_step_r8: assert property (@(posedge clk) disable iff (!cmd_n)
    ($past(tag_vld) && tag_vld) |-> (tag_out == TAG_W'($past(tag_out) + 1'b1)));

endmodule

bind drdy_strobe_gen drdy_strobe_chk #(
  .TAG_W      (TAG_W),
  .FIRST_EDGE (FIRST_EDGE)
) u_chk (
  .clk     (smp_clk),
  .cmd_n   (rdy_rst_n),
  .armed   (armed),
  .strobe  (rdy_strobe),
  .tag_vld (tag_vld),
  .tag_out (tag_out)
);

// File: tb/sim_drdy_strobe_gen.sv
`timescale 1ns/100ps
module sim_drdy_strobe_gen;
  localparam int PER        = 10;
  localparam int WORD_W     = 10;
  localparam int TAG_W      = 8;
  localparam int FIRST_EDGE = 3;
  localparam int D          = 2 * FIRST_EDGE - 1;

  logic              clk = 1'b0;
  logic              rst_cmd = 1'b0;
  logic [WORD_W-1:0] word_in = '0;
  logic [WORD_W-1:0] word_out;
  logic [TAG_W-1:0]  tag_out;
  logic              tag_vld;
  logic              rdy_strobe;

  int n_tests = 0;
  int n_fail  = 0;

  drdy_strobe_gen #(.WORD_W(WORD_W), .TAG_W(TAG_W), .FIRST_EDGE(FIRST_EDGE)) u0 (
    .smp_clk    (clk),
    .rdy_rst_n  (rst_cmd),
    .word_in    (word_in),
    .word_out   (word_out),
    .tag_out    (tag_out),
    .tag_vld    (tag_vld),
    .rdy_strobe (rdy_strobe)
  );

  always #(PER/2) clk = ~clk;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Stimulus pattern, changed 1 ns after each falling edge.
  int pat_mode = 0;
  logic [WORD_W-1:0] pat = 10'd1;
  always @(negedge clk) begin
    #1;
    case (pat_mode)
      0: pat = pat + 1'b1;
      1: pat = ~pat;
      default: pat = WORD_W'(pat * 5 + 3);
    endcase
    word_in = pat;
  end

  // Behavioural reference model.
  bit                m_armed  = 1'b0;
  bit                m_strobe = 1'b0;
  logic [WORD_W-1:0] m_q[$];
  int                m_npush  = 0;

  always @(negedge rst_cmd) begin
    m_armed  = 1'b0;
    m_strobe = 1'b0;
    m_q.delete();
    m_npush  = 0;
  end

  task automatic compare_all();
    bit                evld;
    logic [WORD_W-1:0] eword;
    logic [TAG_W-1:0]  etag;
    evld  = (m_q.size() == D);
    eword = evld ? m_q[0] : '0;
    etag  = evld ? TAG_W'(m_npush - D) : '0;
    check("R3", "strobe vs model", rdy_strobe, m_strobe);
    check("R8", "word_out vs model", word_out, eword);
    check("R8", "tag_out vs model", tag_out, etag);
    check("R6", "tag_vld vs model", tag_vld, evld);
  endtask

  always @(posedge clk) begin
    if (rst_cmd) begin
      m_armed = 1'b1;
      m_q.push_back(word_in);
      if (m_q.size() > D) void'(m_q.pop_front());
      m_npush++;
    end
    #2 compare_all();
  end

  always @(negedge clk) begin
    if (m_armed) m_strobe = !m_strobe;
    #2 compare_all();
  end

  // R7: output word steady from mid high phase across the falling edge.
  bit cmd_fell = 1'b0;
  always @(negedge rst_cmd) cmd_fell = 1'b1;
  always @(posedge clk) begin
    logic [WORD_W-1:0] wmid;
    logic [TAG_W-1:0]  tmid;
    #1.5;
    wmid = word_out;
    tmid = tag_out;
    cmd_fell = 1'b0;
    @(negedge clk);
    #1.5;
    if (!cmd_fell) begin
      check("R7", "word_out across strobe edge", word_out, wmid);
      check("R7", "tag_out across strobe edge", tag_out, tmid);
    end
  end

  // Stop (optional) and release; check first-rise time and third-rise word.
  task automatic restart(input bit do_fall, input bit high_phase, input real off,
                         input real hold, input string req);
    real               t_rel;
    real               o;
    real               exp_d;
    logic [WORD_W-1:0] s0;
    if (high_phase) @(posedge clk); else @(negedge clk);
    if (do_fall) begin
      wait (rdy_strobe == 1'b1);
      if (high_phase) @(posedge clk); else @(negedge clk);
      #(off);
      rst_cmd = 1'b0;
      #0.5;
      check("R1", "strobe low inside stop pulse", rdy_strobe, 0);
      check("R1", "tag_vld low inside stop pulse", tag_vld, 0);
      #(hold - 0.5);
    end else begin
      #(off + hold);
    end
    o = off + hold;
    while (o >= PER) o = o - PER;
    exp_d = high_phase ? (PER - o + PER/2) : (PER - o);
    t_rel = $realtime;
    rst_cmd = 1'b1;
    @(posedge clk);
    s0 = word_in;
    @(posedge rdy_strobe);
    check(req, "release to first strobe rise (x10 ns)",
          longint'(($realtime - t_rel) * 10), longint'(exp_d * 10));
    check("R9", "strobe running after release", rdy_strobe, 1);
    @(posedge rdy_strobe);
    #1;
    check("R6", "tag_vld still low before third rise", tag_vld, 0);
    @(posedge rdy_strobe);
    #1;
    check("R6", "first sample at third strobe rise", word_out, s0);
    check("R6", "tag zero at third strobe rise", tag_out, 0);
    check("R6", "tag_vld at third strobe rise", tag_vld, 1);
  endtask

  initial begin
    // R2: held low with the clock running.
    repeat (4) begin
      @(negedge clk);
      #3;
      check("R2", "strobe while held", rdy_strobe, 0);
      check("R2", "word_out while held", word_out, 0);
      check("R2", "tag_vld while held", tag_vld, 0);
    end
    // R4: release in the low phase, 3 ns after the falling edge.
    restart(1'b0, 1'b0, 3.0, 0.0, "R4");
    repeat (40) @(posedge clk);
    pat_mode = 1;
    // R9 + R1 + R5: 1 ns pulse in the high phase.
    restart(1'b1, 1'b1, 3.0, 1.0, "R5");
    repeat (30) @(posedge clk);
    pat_mode = 2;
    // R2 + R5: long hold across 20 clock periods, release in high phase.
    restart(1'b1, 1'b1, 1.0, real'(20 * PER), "R5");
    repeat (25) @(posedge clk);
    // R9 + R1 + R4: 1 ns pulse in the low phase.
    restart(1'b1, 1'b0, 3.0, 1.0, "R4");
    // R8: long run so the tag wraps.
    pat_mode = 0;
    repeat (300) @(posedge clk);
    #3;
    check("R8", "tag_vld after tag wrap", tag_vld, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(PER * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule